// File: doc/BRIEF.md
# USB Device Status and Interrupt Register Unit

This unit is the software-visible status core of a USB device controller. It holds three words: a device command/status word (device address, enable and pull-up controls, live bus levels and sticky bus-event flags), an interrupt status word, and an interrupt enable word. Bus-side logic signals events to it as single-cycle pulses: bus reset, connect change, suspend change, setup packet arrival, start of frame, and one completion pulse per physical endpoint.

Every bus-state change that newly raises its sticky flag also raises a single device-status interrupt bit. Start of frame and endpoint completions each raise their own interrupt status bit. Software reads and writes the words through a simple one-cycle register port. Flags and interrupt bits are cleared by writing ones to them, so writing back a value just read clears exactly what was seen. A single level interrupt request is raised while any pending status bit is also enabled.

Top module: `usb_devstat_irq`

## Requirements
- R1: After reset, the command/status word reads 0 apart from its two live level bits (17 and 28), the interrupt status and enable words read 0, and `irq` is low.
- R2: A write to the command/status word (register select 0) replaces the device address in bits 6:0, device enable in bit 7 and connect control in bit 16 with the written values.
- R3: Bit 8 of the command/status word is set by a setup pulse and stays set until a write to register select 0 carries a one in bit 8; a zero in bit 8 leaves it set.
- R4: Bits 24 (connect change), 25 (suspend change) and 26 (bus reset) of the command/status word are set by their event pulses and each clears only when a one is written to that bit.
- R5: Bit 17 of the command/status word shows the current suspend level and bit 28 the debounced VBUS level; writes to those bits have no effect.
- R6: Interrupt status bit 31 is set in the cycle after a change event whose flag (bit 24, 25 or 26) was clear; an event whose flag is already set, or a setup pulse, does not set it.
- R7: Interrupt status bit 30 is set by a start-of-frame pulse, and bit i (i below the endpoint count) by a completion pulse on physical endpoint i; bit 0 is control OUT and bit 1 control IN.
- R8: Writing a one to an interrupt status bit (register select 1) clears it, writing a zero leaves it unchanged, and writing back the value just read clears all pending bits.
- R9: When a set event and a write-one-to-clear hit the same flag or status bit in the same cycle, the bit ends set.
- R10: The interrupt enable word (register select 2) stores only bits 31, 30 and the endpoint bits, others read 0; `irq` is high exactly while status AND enable is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command/status, 1 interrupt status, 2 interrupt enable, 3 reads 0 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| ev_bus_reset | input | 1 | Bus reset seen (pulse) |
| ev_conn_chg | input | 1 | Connect state changed (pulse) |
| ev_susp_chg | input | 1 | Suspend state changed (pulse) |
| ev_setup | input | 1 | Setup packet received (pulse) |
| ev_sof | input | 1 | Start of frame (pulse) |
| ep_done | input | NUM_EP | Per-physical-endpoint completion pulses |
| suspend_lvl | input | 1 | Current suspend state |
| vbus_lvl | input | 1 | Debounced VBUS level |
| irq | output | 1 | Level interrupt request |

## Verification
A flag stuck set or lost in this unit is visible on `reg_rdata` on the very next read after the edge that should have changed it, since reads are combinational from the registers. A wrong "newly set" decision shows as bit 31 present or missing one cycle after a repeated change event, which the bench provokes by leaving a flag pending and pulsing the same event again. A mask or enable fault shows on `irq` within one cycle of enabling or clearing a pending bit.

// File: rtl/usb_devstat_pkg.sv
package usb_devstat_pkg;

    localparam int WORD_W    = 32;
    localparam int DEVADDR_W = 7;

    // Command/status word bit positions (software decodes these).
    localparam int CB_ENABLE   = 7;
    localparam int CB_SETUP    = 8;
    localparam int CB_CONNECT  = 16;
    localparam int CB_SUSPEND  = 17;
    localparam int CB_CONN_CHG = 24;
    localparam int CB_SUSP_CHG = 25;
    localparam int CB_RST_CHG  = 26;
    localparam int CB_VBUS     = 28;

    // Interrupt status word bit positions.
    localparam int IB_DEV = 31;
    localparam int IB_SOF = 30;

    typedef enum logic [1:0] {
        SEL_CMD   = 2'd0,
        SEL_ISTAT = 2'd1,
        SEL_IEN   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // Read/write control fields of the command/status word.
    typedef struct packed {
        logic [DEVADDR_W-1:0] dev_addr;
        logic                 enable;
        logic                 connect;
    } cmd_ctrl_t;

    // Sticky flags of the command/status word.
    typedef struct packed {
        logic setup;
        logic conn_chg;
        logic susp_chg;
        logic rst_chg;
    } cmd_flags_t;

    localparam int FLAG_N = $bits(cmd_flags_t);

    function automatic logic [WORD_W-1:0] pack_cmd(
        input cmd_ctrl_t  c,
        input cmd_flags_t f,
        input logic       susp,
        input logic       vbus
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[DEVADDR_W-1:0] = c.dev_addr;
        w[CB_ENABLE]     = c.enable;
        w[CB_CONNECT]    = c.connect;
        w[CB_SETUP]      = f.setup;
        w[CB_CONN_CHG]   = f.conn_chg;
        w[CB_SUSP_CHG]   = f.susp_chg;
        w[CB_RST_CHG]    = f.rst_chg;
        w[CB_SUSPEND]    = susp;
        w[CB_VBUS]       = vbus;
        return w;
    endfunction

    // Bits that exist in the interrupt status and enable words.
    function automatic logic [WORD_W-1:0] irq_mask(input int n_ep);
        logic [WORD_W-1:0] m;
        m = '0;
        m[IB_DEV] = 1'b1;
        m[IB_SOF] = 1'b1;
        for (int i = 0; i < n_ep; i++) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/usb_devstat_w1c.sv
// One sticky bit: set by an event, cleared by a software one, set wins.
module usb_devstat_w1c (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/usb_devstat_cmd.sv
module usb_devstat_cmd
    import usb_devstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  cmd_ctrl_t         wr_ctrl,
    input  cmd_flags_t        wr_clr,
    input  cmd_flags_t        ev_set,
    input  logic              suspend_lvl,
    input  logic              vbus_lvl,
    output logic [WORD_W-1:0] cmd_word,
    output logic              chg_new
);
    cmd_ctrl_t          ctrl_q;
    logic [FLAG_N-1:0]  flag_bits;
    logic [FLAG_N-1:0]  set_bits;
    logic [FLAG_N-1:0]  clr_bits;
    cmd_flags_t         flags;

    always_ff @(posedge clk) begin
        if (rst)        ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wr_ctrl;
    end

    assign set_bits = ev_set;
    assign clr_bits = wr_en ? wr_clr : '0;

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        usb_devstat_w1c u_bit (
            .clk (clk),
            .rst (rst),
            .set (set_bits[i]),
            .clr (clr_bits[i]),
            .q   (flag_bits[i])
        );
    end

    assign flags = cmd_flags_t'(flag_bits);

    // A bus-state change counts only when its flag was clear before.
    always_comb begin
        chg_new = (ev_set.rst_chg  & ~flags.rst_chg)
                | (ev_set.conn_chg & ~flags.conn_chg)
                | (ev_set.susp_chg & ~flags.susp_chg);
    end

    assign cmd_word = pack_cmd(ctrl_q, flags, suspend_lvl, vbus_lvl);
endmodule

// File: rtl/usb_devstat_isr.sv
module usb_devstat_isr
    import usb_devstat_pkg::*;
#(
    parameter int NUM_EP = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wclr,
    input  logic              dev_evt,
    input  logic              sof,
    input  logic [NUM_EP-1:0] ep_done,
    output logic [WORD_W-1:0] istat
);
    localparam logic [WORD_W-1:0] MASK = irq_mask(NUM_EP);

    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] cell_q;

    always_comb begin
        set_vec             = '0;
        set_vec[NUM_EP-1:0] = ep_done;
        set_vec[IB_SOF]     = sof;
        set_vec[IB_DEV]     = dev_evt;
    end

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (MASK[i]) begin : g_live
            usb_devstat_w1c u_bit (
                .clk (clk),
                .rst (rst),
                .set (set_vec[i]),
                .clr (wr_en & wclr[i]),
                .q   (cell_q[i])
            );
        end else begin : g_tied
            assign cell_q[i] = 1'b0;
        end
    end

    assign istat = cell_q;
endmodule

// File: rtl/usb_devstat_irq.sv
module usb_devstat_irq
    import usb_devstat_pkg::*;
#(
    parameter int NUM_EP = 10   // physical endpoints, 2..30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ev_bus_reset,
    input  logic              ev_conn_chg,
    input  logic              ev_susp_chg,
    input  logic              ev_setup,
    input  logic              ev_sof,
    input  logic [NUM_EP-1:0] ep_done,
    input  logic              suspend_lvl,
    input  logic              vbus_lvl,
    output logic              irq
);
    localparam logic [WORD_W-1:0] IEN_MASK = irq_mask(NUM_EP);

    reg_sel_e          sel;
    logic              wr_cmd, wr_istat, wr_ien;
    cmd_ctrl_t         wr_ctrl;
    cmd_flags_t        wr_clr;
    cmd_flags_t        ev_flags;
    logic [WORD_W-1:0] cmd_word;
    logic [WORD_W-1:0] istat_q;
    logic [WORD_W-1:0] ien_q;
    logic              chg_new;

    assign sel      = reg_sel_e'(reg_addr);
    assign wr_cmd   = reg_wr && (sel == SEL_CMD);
    assign wr_istat = reg_wr && (sel == SEL_ISTAT);
    assign wr_ien   = reg_wr && (sel == SEL_IEN);

    always_comb begin
        wr_ctrl.dev_addr = reg_wdata[DEVADDR_W-1:0];
        wr_ctrl.enable   = reg_wdata[CB_ENABLE];
        wr_ctrl.connect  = reg_wdata[CB_CONNECT];
        wr_clr.setup     = reg_wdata[CB_SETUP];
        wr_clr.conn_chg  = reg_wdata[CB_CONN_CHG];
        wr_clr.susp_chg  = reg_wdata[CB_SUSP_CHG];
        wr_clr.rst_chg   = reg_wdata[CB_RST_CHG];
        ev_flags.setup    = ev_setup;
        ev_flags.conn_chg = ev_conn_chg;
        ev_flags.susp_chg = ev_susp_chg;
        ev_flags.rst_chg  = ev_bus_reset;
    end

    usb_devstat_cmd u_cmd (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_cmd),
        .wr_ctrl     (wr_ctrl),
        .wr_clr      (wr_clr),
        .ev_set      (ev_flags),
        .suspend_lvl (suspend_lvl),
        .vbus_lvl    (vbus_lvl),
        .cmd_word    (cmd_word),
        .chg_new     (chg_new)
    );

    usb_devstat_isr #(.NUM_EP(NUM_EP)) u_isr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_istat),
        .wclr    (reg_wdata),
        .dev_evt (chg_new),
        .sof     (ev_sof),
        .ep_done (ep_done),
        .istat   (istat_q)
    );

    always_ff @(posedge clk) begin
        if (rst)         ien_q <= '0;
        else if (wr_ien) ien_q <= reg_wdata & IEN_MASK;
    end

    always_comb begin
        unique case (sel)
            SEL_CMD:   reg_rdata = cmd_word;
            SEL_ISTAT: reg_rdata = istat_q;
            SEL_IEN:   reg_rdata = ien_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |(istat_q & ien_q);
endmodule

// File: rtl/usb_devstat_irq_chk.sv
module usb_devstat_irq_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic        wd_b1,
    input logic        wd_b8,
    input logic        wd_b30,
    input logic        ev_bus_reset,
    input logic        ev_sof,
    input logic [1:0]  ep_lo,
    input logic [31:0] cmd_word,
    input logic [31:0] istat,
    input logic [31:0] ien
);
    // R1: everything but the live levels is clear after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((cmd_word & ~32'h1002_0000) == 32'h0 && istat == 32'h0 && ien == 32'h0));

    // R3: setup flag holds unless a one is written to it
    a_r3_setup_holds: assert property (@(posedge clk) disable iff (rst)
        (cmd_word[8] && !(reg_wr && reg_addr == 2'd0 && wd_b8)) |=> cmd_word[8]);

    // R6: a fresh bus reset raises the device-status interrupt
    a_r6_dev_int_new: assert property (@(posedge clk) disable iff (rst)
        (ev_bus_reset && !cmd_word[26]) |=> istat[31]);

    // R7: start of frame and control endpoints land in their bits
    a_r7_sof_bit: assert property (@(posedge clk) disable iff (rst)
        ev_sof |=> istat[30]);
    a_r7_ctrl_out_bit: assert property (@(posedge clk) disable iff (rst)
        ep_lo[0] |=> istat[0]);

    // R8: a written one clears a status bit with no competing event
    a_r8_sof_w1c: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1 && wd_b30 && !ev_sof) |=> !istat[30]);

    // R9: set beats clear on the same cycle
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (ep_lo[1] && reg_wr && reg_addr == 2'd1 && wd_b1) |=> istat[1]);
endmodule

bind usb_devstat_irq usb_devstat_irq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .wd_b1        (reg_wdata[1]),
    .wd_b8        (reg_wdata[8]),
    .wd_b30       (reg_wdata[30]),
    .ev_bus_reset (ev_bus_reset),
    .ev_sof       (ev_sof),
    .ep_lo        (ep_done[1:0]),
    .cmd_word     (cmd_word),
    .istat        (istat_q),
    .ien          (ien_q)
);

// File: tb/usb_devstat_irq_test.sv
`timescale 1ns/1ps
module usb_devstat_irq_test;
    localparam int NEP = 10;
    localparam logic [31:0] MASK = 32'hC000_0000 | ((32'd1 << NEP) - 32'd1);
    localparam logic [31:0] CTRL = 32'h0000_0025;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_addr = 2'd0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            ev_bus_reset = 1'b0, ev_conn_chg = 1'b0, ev_susp_chg = 1'b0;
    logic            ev_setup = 1'b0, ev_sof = 1'b0;
    logic [NEP-1:0]  ep_done = '0;
    logic            suspend_lvl = 1'b0, vbus_lvl = 1'b0;
    logic            irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usb_devstat_irq #(.NUM_EP(NEP)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_bus_reset(ev_bus_reset), .ev_conn_chg(ev_conn_chg),
        .ev_susp_chg(ev_susp_chg), .ev_setup(ev_setup), .ev_sof(ev_sof),
        .ep_done(ep_done), .suspend_lvl(suspend_lvl), .vbus_lvl(vbus_lvl),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic check_reg(input string tag, input logic [1:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // bits: 4 bus_reset, 3 conn, 2 susp, 1 setup, 0 sof
    task automatic pulse(input logic [4:0] ev, input logic [NEP-1:0] eps);
        @(negedge clk);
        {ev_bus_reset, ev_conn_chg, ev_susp_chg, ev_setup, ev_sof} = ev;
        ep_done = eps;
        @(negedge clk);
        {ev_bus_reset, ev_conn_chg, ev_susp_chg, ev_setup, ev_sof} = '0;
        ep_done = '0;
    endtask

    task automatic t_reset();
        check_reg("R1 cmd after reset", 2'd0, 32'h0);
        check_reg("R1 istat after reset", 2'd1, 32'h0);
        check_reg("R1 ien after reset", 2'd2, 32'h0);
        check_reg("R1 unused select", 2'd3, 32'h0);
        check("R1 irq after reset", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_ctrl();
        wr(2'd0, 32'h0001_00FF);
        check_reg("R2 addr/enable/connect set", 2'd0, 32'h0001_00FF);
        wr(2'd0, 32'h1002_0025);   // r5_ level bits written high are ignored
        check_reg("R2 R5 ctrl replaced, levels ignore write", 2'd0, CTRL);
    endtask

    task automatic t_levels();
        @(negedge clk);
        suspend_lvl = 1'b1; vbus_lvl = 1'b1;
        check_reg("R5 live levels high", 2'd0, 32'h1002_0025);
        suspend_lvl = 1'b0;
        check_reg("R5 suspend dropped", 2'd0, 32'h1000_0025);
        vbus_lvl = 1'b0;
    endtask

    task automatic t_setup();
        pulse(5'b00010, '0);
        check_reg("R3 setup flag set", 2'd0, CTRL | 32'h100);
        check_reg("R6 setup gives no device irq", 2'd1, 32'h0);
        wr(2'd0, CTRL);
        check_reg("R3 zero write keeps setup", 2'd0, CTRL | 32'h100);
        wr(2'd0, CTRL | 32'h100);
        check_reg("R3 one write clears setup", 2'd0, CTRL);
    endtask

    task automatic t_change();
        pulse(5'b10000, '0);
        check_reg("R4 bus reset flag", 2'd0, CTRL | 32'h0400_0000);
        check_reg("R6 device irq on reset", 2'd1, 32'h8000_0000);
        pulse(5'b01000, '0);
        check_reg("R4 connect change flag", 2'd0, CTRL | 32'h0500_0000);
        pulse(5'b00100, '0);
        check_reg("R4 suspend change flag", 2'd0, CTRL | 32'h0700_0000);
        wr(2'd0, CTRL | 32'h0100_0000);
        check_reg("R4 clear only connect change", 2'd0, CTRL | 32'h0600_0000);
    endtask

    task automatic t_repeat();
        wr(2'd1, 32'h8000_0000);
        check_reg("R8 device irq cleared", 2'd1, 32'h0);
        pulse(5'b10000, '0);
        check_reg("R6 repeat reset no device irq", 2'd1, 32'h0);
        wr(2'd0, CTRL | 32'h0600_0000);
        check_reg("R4 flags cleared", 2'd0, CTRL);
        pulse(5'b10000, '0);
        check_reg("R6 fresh reset sets device irq", 2'd1, 32'h8000_0000);
        wr(2'd0, CTRL | 32'h0400_0000);
        wr(2'd1, 32'hFFFF_FFFF);
        check_reg("R8 all cleared", 2'd1, 32'h0);
    endtask

    task automatic t_ep();
        pulse(5'b00000, NEP'(1));
        check_reg("R7 control OUT bit0", 2'd1, 32'h1);
        pulse(5'b00000, NEP'(2));
        check_reg("R7 control IN bit1", 2'd1, 32'h3);
        pulse(5'b00000, NEP'(1) << (NEP - 1));
        check_reg("R7 top endpoint", 2'd1, 32'h3 | (32'd1 << (NEP - 1)));
        pulse(5'b00001, '0);
        check_reg("R7 sof bit30", 2'd1, 32'h4000_0003 | (32'd1 << (NEP - 1)));
        check("R10 irq low while disabled", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(2'd1, 32'h0);
        check_reg("R8 zero write keeps", 2'd1, 32'h4000_0003 | (32'd1 << (NEP - 1)));
        wr(2'd1, 32'h2);
        check_reg("R8 single bit clear", 2'd1, 32'h4000_0001 | (32'd1 << (NEP - 1)));
        rd(2'd1, v);
        wr(2'd1, v);
        check_reg("R8 write back clears all", 2'd1, 32'h0);
    endtask

    task automatic t_ien();
        wr(2'd2, 32'hFFFF_FFFF);
        check_reg("R10 enable mask", 2'd2, MASK);
        check("R10 irq low without status", {31'd0, irq}, 32'h0);
        pulse(5'b00000, NEP'(8));
        check("R10 irq high on enabled bit", {31'd0, irq}, 32'h1);
        wr(2'd2, 32'h0);
        check("R10 irq low after disable", {31'd0, irq}, 32'h0);
        wr(2'd1, 32'h8);
        check_reg("R8 ep3 cleared", 2'd1, 32'h0);
    endtask

    task automatic t_same();
        @(negedge clk);
        ev_setup = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = CTRL | 32'h100;
        @(negedge clk);
        ev_setup = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        check_reg("R9 setup set wins", 2'd0, CTRL | 32'h100);
        wr(2'd0, CTRL | 32'h100);
        @(negedge clk);
        ep_done = NEP'(4); reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h4;
        @(negedge clk);
        ep_done = '0; reg_wr = 1'b0; reg_wdata = '0;
        check_reg("R9 endpoint set wins", 2'd1, 32'h4);
        wr(2'd1, 32'h4);
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_levels();
        t_setup();
        t_change();
        t_repeat();
        t_ep();
        t_w1c();
        t_ien();
        t_same();
        done = 1'b1;
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_up();
        end
    end
endmodule